// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This unit turns one block-transfer request into a run of single-word memory transfers. A request gives a base address, a register mask with one bit per register, an addressing mode, a load/store select, a writeback enable and a privilege flag. The unit then presents one transfer per cycle. Each transfer carries a word address, the register index it moves and a write strobe. A memory ready input stalls the walk.

When the last transfer has been accepted, the unit raises a one-cycle completion pulse. In that cycle it reports the value to write back to the base register, whether the saved status word must be restored, and whether the program-counter register was loaded, so that a fetch front end can redirect. The register-bank select is held for the whole operation, because the external register file needs it during every transfer. The memory system and the register file are outside the block.

Top module: `multi_xfer_seq`

## Requirements
- R1: With n the number of set mask bits and W the word size (4 bytes), the first transfer address depends on the mode. Mode 0 starts at base. Mode 1 starts at base+W. Mode 2 starts at base−W·n+W. Mode 3 starts at base−W·n. All arithmetic wraps modulo 2^ADDR_W.
- R2: Each transfer presents the lowest-numbered register still pending on `xfer_reg_o`, so registers move in ascending index order. Each set mask bit is transferred exactly once.
- R3: After each accepted transfer (`xfer_valid_o` and `mem_ready_i` both high), the next transfer address is the previous one plus W, in every mode.
- R4: While `xfer_valid_o` is high and `mem_ready_i` is low, the address and the register index are held unchanged into the next cycle.
- R5: `xfer_write_o` is 1 for a store and 0 for a load, on every transfer.
- R6: In the completion cycle, `wb_valid_o` equals the writeback enable. `wb_addr_o` is base+W·n for modes 0 and 1, and base−W·n for modes 2 and 3 (mode bit 1 selects decrement). `wb_valid_o` is never high outside the completion cycle.
- R7: An all-zero mask performs no transfer, and `done_o` rises in the cycle after the start.
- R8: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle, and low in the cycle after `done_o`. `done_o` follows the last accepted transfer by one cycle.
- R9: `restore_status_o` pulses with `done_o` only for a load that has the privilege flag set and the top register (index 15) in its mask.
- R10: While busy, `user_bank_o` is 1 when the privilege flag is set and the operation is not a load that includes register 15. This covers any store with the flag set.
- R11: `pc_loaded_o` pulses with `done_o` for any load whose mask includes register 15, whatever the privilege flag.
- R12: A start pulse while busy is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| base_i | input | ADDR_W | Base register value |
| mask_i | input | NREG | Register mask, bit i for register i |
| mode_i | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| is_load_i | input | 1 | 1 load, 0 store |
| wb_en_i | input | 1 | Base writeback enable |
| priv_s_i | input | 1 | Privilege side-effect flag |
| mem_ready_i | input | 1 | Memory accepts the presented transfer |
| busy_o | output | 1 | Operation in progress |
| xfer_valid_o | output | 1 | A transfer is presented |
| xfer_addr_o | output | ADDR_W | Transfer word address |
| xfer_reg_o | output | $clog2(NREG) | Register index of the transfer |
| xfer_write_o | output | 1 | Transfer is a write to memory |
| done_o | output | 1 | Completion pulse |
| wb_valid_o | output | 1 | Base writeback requested |
| wb_addr_o | output | ADDR_W | Writeback value for the base |
| user_bank_o | output | 1 | Access the user-mode register bank |
| restore_status_o | output | 1 | Copy saved status into current status |
| pc_loaded_o | output | 1 | Register 15 was loaded |

## Verification
The bench builds the block with its defaults: 16 registers, 32-bit addresses and 4-byte words. With these values, the full mask places register 15 at the far end of a 64-byte window. A base of 0x10 combined with the decrement modes wraps the start address through zero, which exercises the modular arithmetic.

A pseudo-random ready pattern stalls transfers in every position, including the first and the last. Single-bit masks at either end check the point where the first transfer is also the last.

// File: rtl/multi_xfer_pkg.sv
package multi_xfer_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/xfer_base_calc.sv
module xfer_base_calc
  import multi_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] wb_addr_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  // Total bytes covered by the mask: popcount times the word size.
  function automatic logic [ADDR_W-1:0] span_bytes(input logic [NREG-1:0] m);
    logic [ADDR_W-1:0] cnt;
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + ADDR_W'(m[i]);
    return cnt * STEP;
  endfunction

  logic [ADDR_W-1:0] span_w;
  assign span_w = span_bytes(mask_i);

  always_comb begin
    unique case (amode_e'(mode_i))
      AM_INC_AFTER:  first_addr_o = base_i;
      AM_INC_BEFORE: first_addr_o = base_i + STEP;
      AM_DEC_AFTER:  first_addr_o = base_i - span_w + STEP;
      default:       first_addr_o = base_i - span_w;
    endcase
  end

  // Mode bit 1 selects the decrementing direction.
  assign wb_addr_o = mode_i[1] ? (base_i - span_w) : (base_i + span_w);

endmodule

// File: rtl/xfer_pick.sv
module xfer_pick #(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]         pending_i,
  output logic [$clog2(NREG)-1:0] idx_o,
  output logic [NREG-1:0]         rest_o
);

  localparam int IDX_W = $clog2(NREG);

  // Lowest pending bit selected; the rest keeps the higher ones.
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pending_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign rest_o = pending_i & (pending_i - NREG'(1));

endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import multi_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [NREG-1:0]         mask_i,
  input  logic [1:0]              mode_i,
  input  logic                    is_load_i,
  input  logic                    wb_en_i,
  input  logic                    priv_s_i,
  input  logic                    mem_ready_i,
  output logic                    busy_o,
  output logic                    xfer_valid_o,
  output logic [ADDR_W-1:0]       xfer_addr_o,
  output logic [$clog2(NREG)-1:0] xfer_reg_o,
  output logic                    xfer_write_o,
  output logic                    done_o,
  output logic                    wb_valid_o,
  output logic [ADDR_W-1:0]       wb_addr_o,
  output logic                    user_bank_o,
  output logic                    restore_status_o,
  output logic                    pc_loaded_o
);

  localparam int PC_IDX = NREG - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_state_e        state_q;
  logic [NREG-1:0]   pend_q;
  logic [ADDR_W-1:0] addr_q, wb_q;
  logic              load_q, wben_q, priv_q, top_q;

  logic [ADDR_W-1:0] first_w, wbcalc_w;
  logic [NREG-1:0]   rest_w;
  logic              launch_w, accept_w, last_w;

  xfer_base_calc #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_calc (
    .base_i(base_i), .mask_i(mask_i), .mode_i(mode_i),
    .first_addr_o(first_w), .wb_addr_o(wbcalc_w)
  );

  xfer_pick #(.NREG(NREG)) u_pick (
    .pending_i(pend_q), .idx_o(xfer_reg_o), .rest_o(rest_w)
  );

  assign launch_w = start_i && (state_q == SEQ_IDLE);
  assign accept_w = xfer_valid_o && mem_ready_i;
  assign last_w   = accept_w && (rest_w == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      load_q  <= 1'b0;
      wben_q  <= 1'b0;
      priv_q  <= 1'b0;
      top_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (launch_w) begin
          pend_q  <= mask_i;
          addr_q  <= first_w;
          wb_q    <= wbcalc_w;
          load_q  <= is_load_i;
          wben_q  <= wb_en_i;
          priv_q  <= priv_s_i;
          top_q   <= mask_i[PC_IDX];
          state_q <= (mask_i == '0) ? SEQ_DONE : SEQ_RUN;
        end
        SEQ_RUN: if (accept_w) begin
          pend_q <= rest_w;
          addr_q <= addr_q + STEP;
          if (last_w) state_q <= SEQ_DONE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o           = (state_q != SEQ_IDLE);
  assign xfer_valid_o     = (state_q == SEQ_RUN);
  assign xfer_addr_o      = addr_q;
  assign xfer_write_o     = !load_q;
  assign done_o           = (state_q == SEQ_DONE);
  assign wb_valid_o       = done_o && wben_q;
  assign wb_addr_o        = wb_q;
  assign user_bank_o      = busy_o && priv_q && !(load_q && top_q);
  assign restore_status_o = done_o && priv_q && load_q && top_q;
  assign pc_loaded_o      = done_o && load_q && top_q;

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + STEP));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !mem_ready_i) |=>
      (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (!xfer_valid_o || xfer_reg_o > $past(xfer_reg_o)));

  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_w && mask_i == '0) |=> done_o);

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> busy_o);

  p_wb_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o);

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_status_o |-> (pc_loaded_o && !user_bank_o));

  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && start_i && !mem_ready_i) |=> $stable(xfer_addr_o));

endmodule

// File: tb/multi_xfer_seq_test.sv
module multi_xfer_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic [1:0]  mode_i = '0;
  logic        is_load_i = 1'b0, wb_en_i = 1'b0, priv_s_i = 1'b0;
  logic        mem_ready_i = 1'b1;
  logic        busy_o, xfer_valid_o, xfer_write_o, done_o, wb_valid_o;
  logic        user_bank_o, restore_status_o, pc_loaded_o;
  logic [31:0] xfer_addr_o, wb_addr_o;
  logic [3:0]  xfer_reg_o;

  multi_xfer_seq uut (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference model state
  int          m_phase = 0;  // 0 idle, 1 transferring, 2 completion
  int          q_reg[$];
  logic [31:0] m_addr, m_wb;
  bit          m_load, m_wben, m_s, m_top, m_zero, m_first, m_stalled, m_intrude;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      q_reg.delete();
    end else begin
      case (m_phase)
        0: if (start_i) begin
          int n;
          n = 0;
          for (int i = 0; i < 16; i++) if (mask_i[i]) begin n++; q_reg.push_back(i); end
          case (mode_i)
            2'd0: m_addr = base_i;
            2'd1: m_addr = base_i + 32'd4;
            2'd2: m_addr = base_i - 32'(4 * n) + 32'd4;
            default: m_addr = base_i - 32'(4 * n);
          endcase
          m_wb      = (mode_i >= 2) ? base_i - 32'(4 * n) : base_i + 32'(4 * n);
          m_load    = is_load_i; m_wben = wb_en_i; m_s = priv_s_i; m_top = mask_i[15];
          m_zero    = (n == 0);
          m_first   = 1; m_stalled = 0; m_intrude = 0;
          m_phase   = (n == 0) ? 2 : 1;
        end
        1: begin
          if (start_i) m_intrude = 1;
          if (mem_ready_i) begin
            void'(q_reg.pop_front());
            m_addr = m_addr + 32'd4;
            m_first = 0; m_stalled = 0;
            if (q_reg.size() == 0) m_phase = 2;
          end else m_stalled = 1;
        end
        default: m_phase = 0;
      endcase
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy_o == (m_phase != 0), "R8 busy", 32'(busy_o), 32'(m_phase != 0));
      chk(xfer_valid_o == (m_phase == 1), m_zero ? "R7 valid" : "R2 valid",
          32'(xfer_valid_o), 32'(m_phase == 1));
      chk(done_o == (m_phase == 2), m_zero ? "R7 done" : "R8 done", 32'(done_o), 32'(m_phase == 2));
      if (m_phase == 1 && xfer_valid_o) begin
        chk(xfer_addr_o == m_addr, m_stalled ? "R4 addr" : (m_first ? "R1 first addr" : "R3 addr"),
            xfer_addr_o, m_addr);
        chk(xfer_reg_o == q_reg[0], m_intrude ? "R12 reg" : (m_stalled ? "R4 reg" : "R2 reg"),
            32'(xfer_reg_o), 32'(q_reg[0]));
        chk(xfer_write_o == !m_load, "R5 write", 32'(xfer_write_o), 32'(!m_load));
      end
      if (m_phase != 0)
        chk(user_bank_o == (m_s && !(m_load && m_top)), "R10 user bank",
            32'(user_bank_o), 32'(m_s && !(m_load && m_top)));
      chk(wb_valid_o == (m_phase == 2 && m_wben), "R6 wb valid", 32'(wb_valid_o), 32'(m_phase == 2 && m_wben));
      if (m_phase == 2) begin
        if (m_wben) chk(wb_addr_o == m_wb, "R6 wb addr", wb_addr_o, m_wb);
        chk(restore_status_o == (m_s && m_load && m_top), "R9 restore",
            32'(restore_status_o), 32'(m_s && m_load && m_top));
        chk(pc_loaded_o == (m_load && m_top), "R11 pc loaded", 32'(pc_loaded_o), 32'(m_load && m_top));
      end else begin
        chk(!restore_status_o && !pc_loaded_o, "R9 R11 idle pulses",
            32'({restore_status_o, pc_loaded_o}), 32'd0);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    mem_ready_i = stall_en ? lfsr[0] : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_op(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                        input bit ld, input bit wb, input bit s, input bit intrude);
    base_i = b; mask_i = m; mode_i = md; is_load_i = ld; wb_en_i = wb; priv_s_i = s;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    base_i = 32'hDEAD_0000; mask_i = 16'h5A5A; mode_i = ~md;
    if (intrude) begin
      tick();
      start_i = 1'b1; mask_i = 16'hFFFF; base_i = '0;  // R12: must be ignored
      tick();
      start_i = 1'b0;
    end
    while (busy_o || m_phase != 0) tick();
    tick();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(!busy_o && !xfer_valid_o && !done_o, "R8 reset state",
        32'({busy_o, xfer_valid_o, done_o}), 32'd0);
    // R1 each mode, R6 writeback
    run_op(32'h0000_1000, 16'h8421, 2'd0, 1, 1, 0, 0);
    run_op(32'h0000_1000, 16'h8421, 2'd1, 0, 1, 0, 0);
    run_op(32'h0000_1000, 16'h8421, 2'd2, 1, 1, 0, 0);
    run_op(32'h0000_1000, 16'h8421, 2'd3, 0, 1, 0, 0);
    // R7 empty mask
    run_op(32'h0000_2000, 16'h0000, 2'd1, 1, 1, 1, 0);
    // wrap through zero with full mask
    run_op(32'h0000_0010, 16'hFFFF, 2'd3, 0, 1, 1, 0);
    run_op(32'h0000_0010, 16'hFFFF, 2'd2, 1, 1, 1, 0);
    // R9 restore, R10 user bank, R11 pc load
    run_op(32'h0000_4000, 16'h8003, 2'd0, 1, 0, 1, 0);
    run_op(32'h0000_4000, 16'h0070, 2'd1, 1, 0, 1, 0);
    run_op(32'h0000_4000, 16'h8070, 2'd0, 0, 0, 1, 0);
    run_op(32'h0000_4000, 16'h8000, 2'd3, 1, 1, 0, 0);
    run_op(32'h0000_4000, 16'h0001, 2'd2, 0, 1, 0, 0);
    // R4 stalls, R12 intrusion
    stall_en = 1;
    run_op(32'h0000_8000, 16'hF0F1, 2'd1, 1, 1, 0, 1);
    run_op(32'h0000_8000, 16'hFFFF, 2'd2, 0, 1, 1, 1);
    run_op(32'h0000_8000, 16'h8001, 2'd3, 1, 1, 1, 1);
    run_op(32'h0000_8000, 16'h0000, 2'd0, 1, 1, 0, 1);
    stall_en = 0;
    repeat (4) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule